// File: doc/BRIEF.md
# Asynchronous/Synchronous Serial Transmit Engine

This block turns bytes from a one-entry holding register into a serial bit stream on a single line output. Bit timing comes from a transmit-clock strobe, `tx_tick`, which marks each falling edge of the transmit clock inside the core clock domain. In asynchronous mode each character is framed with a low start bit, 5 to 8 data bits (least significant first), an optional parity bit and 1, 1.5 or 2 high stop bits. Each bit lasts 1, 16 or 64 strobes. In synchronous mode characters carry only data and optional parity, at one bit per strobe.

While the transmitter is enabled in synchronous mode and no data is queued, the engine keeps the line busy with programmed fill characters. It sends either one fill byte over and over or two fill bytes in turn. The transmitter runs only while the enable command is set and the clear-to-send input is low. A character already being shifted always completes. A byte written while the transmitter is stopped waits in the holding register. A break control forces the line low.

Top module: `usart_tx_serializer`

## Requirements
- R1: After reset `line_out` is 1, `hold_ready` is 1 and `all_sent` is 1.
- R2: While `force_break` is 1, `line_out` is 0 from the next clock on. The line returns to its normal value one clock after `force_break` falls.
- R3: `hold_ready` is 1 exactly when the holding register is empty. A write with `hold_ready` at 1 stores `wr_data` and drives `hold_ready` low on the next clock. A write while `hold_ready` is 0 is discarded, and only the byte already held is sent. `hold_ready` rises again on the strobe that moves the byte into the shifter.
- R4: An asynchronous character (`async_mode`=1) is sent as follows: a 0 start bit, then 5+`len_code` data bits least significant first, then a parity bit if `par_on`=1, then stop bits at 1. The parity bit is the XOR of the data bits when `par_even`=1, and its inverse when `par_even`=0. `stop_code` 0, 1 and 2 select 1, 1.5 and 2 stop bits.
- R5: `rate_code` 0, 1 and 2 make every asynchronous bit last 1, 16 or 64 strobes. The last stop bit of a 1.5-stop frame lasts half the bit time. At rate code 0 it lasts a full bit, which gives 2 stop bits. A queued character starts on the strobe right after the previous one ends.
- R6: A synchronous character (`async_mode`=0) consists of the 5+`len_code` data bits, least significant first, then the optional parity bit. It has no start or stop bits, and each bit lasts one strobe.
- R7: In synchronous mode, when a character ends or the line is idle, a strobe with the transmitter enabled and the holding register empty loads a fill character. With `dual_sync`=0 that character is always `sync_a`. With `dual_sync`=1 it alternates `sync_a` then `sync_b`. Sending a data byte restarts the fill order at `sync_a`.
- R8: A new character is loaded only while `tx_enable`=1 and `cts_n`=0. Stopping the transmitter lets the character in the shifter finish. A byte written while stopped stays held and goes out once the transmitter is enabled again. With no character in the shifter, `line_out` is 1 in both modes.
- R9: `all_sent` is 0 while a data byte is being shifted, and also while a byte is held with the transmitter enabled. Otherwise it is 1, including during synchronous fill and while a byte is held with the transmitter stopped.
- R10: Apart from the break control, `line_out` changes only on the clock that samples `tx_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_tick | input | 1 | One-clock strobe per transmit-clock falling edge |
| async_mode | input | 1 | 1 = asynchronous framing, 0 = synchronous |
| len_code | input | 2 | Data bits = 5 + len_code |
| par_on | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| stop_code | input | 2 | 0 = 1 stop, 1 = 1.5 stop, 2 = 2 stop |
| rate_code | input | 2 | 0 = x1, 1 = x16, 2 = x64 strobes per bit (async) |
| dual_sync | input | 1 | 1 = fill alternates two bytes |
| sync_a | input | 8 | First fill byte |
| sync_b | input | 8 | Second fill byte |
| tx_enable | input | 1 | Transmit enable command |
| cts_n | input | 1 | Clear to send, active low |
| force_break | input | 1 | Hold the line low |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| line_out | output | 1 | Serial data line |
| hold_ready | output | 1 | Holding register can accept a byte |
| all_sent | output | 1 | No data byte in flight or pending |

## Verification
The bench sweeps every combination of data length, parity and stop setting, and sends two characters back to back. A wrong stop-bit count or a wrong half-stop length therefore moves the second start bit, and a wrong parity sense flips one bit of the captured stream. Fill sequences are checked after a queued data byte. A design that failed to restart the pair order would send `sync_b` first. Disable tests stop the transmitter in the middle of a character. An engine that cut the character short, or that sent a byte written while stopped, would produce a visibly different line pattern. A write to a full holding register is checked so that an overwrite shows up as the wrong byte on the line.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2,
    STOP_TWO_ALT  = 2'd3
  } stop_e;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_MID = 2'd1,
    RATE_HI  = 2'd2,
    RATE_ALT = 2'd3
  } rate_e;

endpackage

// File: rtl/usart_tx_holding.sv
module usart_tx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full_q,
  output logic              full_d,
  output logic [DATA_W-1:0] data_q
);

  always_comb begin
    full_d = full_q;
    if (take)
      full_d = 1'b0;
    else if (wr_valid)
      full_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_valid && !full_q)
        data_q <= wr_data;
    end
  end

endmodule

// File: rtl/usart_tx_framer.sv
module usart_tx_framer
  import usart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               async_mode,
  input  logic [1:0]         len_code,
  input  logic               par_on,
  input  logic               par_even,
  input  logic [1:0]         stop_code,
  input  logic [DATA_W-1:0]  char_in,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   frame_bits,
  output logic               half_stop
);

  localparam int MIN_BITS = DATA_W - 3;
  localparam int IDX_W    = $clog2(FRAME_W);

  logic [LEN_W-1:0]  dlen;
  logic [LEN_W-1:0]  off;
  logic [LEN_W-1:0]  stops;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] masked;
  logic              par_bit;
  stop_e             stop_sel;

  assign dlen     = LEN_W'(MIN_BITS) + LEN_W'(len_code);
  assign off      = async_mode ? LEN_W'(1) : LEN_W'(0);
  assign stop_sel = stop_e'(stop_code);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep[i]   = (LEN_W'(i) < dlen);
    assign masked[i] = char_in[i] & keep[i];
  end

  assign par_bit = (^masked) ^ ~par_even;

  always_comb begin
    frame = '1;
    if (async_mode)
      frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (keep[i])
        frame[IDX_W'(off + LEN_W'(i))] = char_in[i];
    end
    if (par_on)
      frame[IDX_W'(off + dlen)] = par_bit;
  end

  always_comb begin
    stops = LEN_W'(0);
    if (async_mode)
      stops = (stop_sel == STOP_ONE) ? LEN_W'(1) : LEN_W'(2);
  end

  assign frame_bits = off + dlen + LEN_W'(par_on) + stops;
  assign half_stop  = async_mode && (stop_sel == STOP_ONE_HALF);

endmodule

// File: rtl/usart_tx_slot_timer.sv
module usart_tx_slot_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             clear,
  input  logic [CNT_W-1:0] slot_len,
  output logic             slot_end
);

  logic [CNT_W-1:0] cnt_q;

  assign slot_end = adv && !clear && (cnt_q == slot_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= slot_end ? '0 : cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/usart_tx_serializer.sv
module usart_tx_serializer
  import usart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FACT_MID = 16,
  parameter int FACT_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_tick,
  input  logic              async_mode,
  input  logic [1:0]        len_code,
  input  logic              par_on,
  input  logic              par_even,
  input  logic [1:0]        stop_code,
  input  logic [1:0]        rate_code,
  input  logic              dual_sync,
  input  logic [DATA_W-1:0] sync_a,
  input  logic [DATA_W-1:0] sync_b,
  input  logic              tx_enable,
  input  logic              cts_n,
  input  logic              force_break,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              line_out,
  output logic              hold_ready,
  output logic              all_sent
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(FACT_HI) + 1;

  logic               en_ok;
  logic               hold_full, hold_full_d;
  logic [DATA_W-1:0]  hold_data;
  logic [DATA_W-1:0]  char_src;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_bits;
  logic               frame_half;
  logic [CNT_W-1:0]   rate_fact;
  logic [CNT_W-1:0]   slot_len;
  logic               slot_end, last_end, do_load;

  logic               busy_q, busy_d;
  logic               data_q, data_d;
  logic               half_q, half_d;
  logic               ph_q, ph_d;
  logic [CNT_W-1:0]   fact_q, fact_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               line_d, empty_d;
  logic               empty_q;
  rate_e              rate_sel;

  assign en_ok    = tx_enable & ~cts_n;
  assign rate_sel = rate_e'(rate_code);

  always_comb begin
    case (rate_sel)
      RATE_X1:  rate_fact = CNT_W'(1);
      RATE_MID: rate_fact = CNT_W'(FACT_MID);
      default:  rate_fact = CNT_W'(FACT_HI);
    endcase
  end

  assign char_src = hold_full ? hold_data : (ph_q ? sync_b : sync_a);

  usart_tx_holding #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (do_load && hold_full),
    .full_q   (hold_full),
    .full_d   (hold_full_d),
    .data_q   (hold_data)
  );

  usart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) i_framer (
    .async_mode (async_mode),
    .len_code   (len_code),
    .par_on     (par_on),
    .par_even   (par_even),
    .stop_code  (stop_code),
    .char_in    (char_src),
    .frame      (frame),
    .frame_bits (frame_bits),
    .half_stop  (frame_half)
  );

  assign slot_len = (half_q && left_q == LEN_W'(1)) ? (fact_q >> 1) : fact_q;

  usart_tx_slot_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .adv      (tx_tick),
    .clear    (!busy_q),
    .slot_len (slot_len),
    .slot_end (slot_end)
  );

  assign last_end = slot_end && (left_q == LEN_W'(1));
  assign do_load  = tx_tick && (!busy_q || last_end) && en_ok
                    && (hold_full || !async_mode);

  always_comb begin
    busy_d  = busy_q;
    data_d  = data_q;
    half_d  = half_q;
    ph_d    = ph_q;
    fact_d  = fact_q;
    shreg_d = shreg_q;
    left_d  = left_q;
    if (do_load) begin
      busy_d  = 1'b1;
      data_d  = hold_full;
      half_d  = frame_half && (rate_fact > CNT_W'(1));
      fact_d  = async_mode ? rate_fact : CNT_W'(1);
      shreg_d = frame;
      left_d  = frame_bits;
      ph_d    = hold_full ? 1'b0 : (dual_sync & ~ph_q);
    end else if (slot_end) begin
      if (left_q == LEN_W'(1)) begin
        busy_d = 1'b0;
      end else begin
        shreg_d = shreg_q >> 1;
        left_d  = left_q - LEN_W'(1);
      end
    end
    line_d  = force_break ? 1'b0 : (busy_d ? shreg_d[0] : 1'b1);
    empty_d = !(busy_d && data_d) && (!hold_full_d || !en_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      data_q   <= 1'b0;
      half_q   <= 1'b0;
      ph_q     <= 1'b0;
      fact_q   <= CNT_W'(1);
      shreg_q  <= '1;
      left_q   <= '0;
      line_out <= 1'b1;
      empty_q  <= 1'b1;
    end else begin
      busy_q   <= busy_d;
      data_q   <= data_d;
      half_q   <= half_d;
      ph_q     <= ph_d;
      fact_q   <= fact_d;
      shreg_q  <= shreg_d;
      left_q   <= left_d;
      line_out <= line_d;
      empty_q  <= empty_d;
    end
  end

  assign hold_ready = ~hold_full;
  assign all_sent   = empty_q;

endmodule

// File: rtl/usart_tx_checker.sv
module usart_tx_checker (
  input logic clk,
  input logic rst,
  input logic tx_tick,
  input logic force_break,
  input logic wr_valid,
  input logic line_out,
  input logic hold_ready,
  input logic all_sent
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (line_out && hold_ready && all_sent));

  p_break_low_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_break)) |-> !line_out);

  p_write_fills_r3: assert property (@(posedge clk) disable iff (rst)
    (hold_ready && wr_valid) |=> !hold_ready);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold_ready && !tx_tick) |=> !hold_ready);

  p_tick_paced_r10: assert property (@(posedge clk) disable iff (rst)
    (!tx_tick && !force_break && !$past(force_break)) |=> $stable(line_out));

endmodule

bind usart_tx_serializer usart_tx_checker i_usart_tx_checker (
  .clk         (clk),
  .rst         (rst),
  .tx_tick     (tx_tick),
  .force_break (force_break),
  .wr_valid    (wr_valid),
  .line_out    (line_out),
  .hold_ready  (hold_ready),
  .all_sent    (all_sent)
);

// File: tb/test_usart_tx_serializer.sv
module test_usart_tx_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int BUF_N      = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_tick = 1'b0;
  logic       async_mode = 1'b1;
  logic [1:0] len_code = 2'd3;
  logic       par_on = 1'b0;
  logic       par_even = 1'b0;
  logic [1:0] stop_code = 2'd0;
  logic [1:0] rate_code = 2'd0;
  logic       dual_sync = 1'b0;
  logic [7:0] sync_a = 8'h00;
  logic [7:0] sync_b = 8'h00;
  logic       tx_enable = 1'b0;
  logic       cts_n = 1'b0;
  logic       force_break = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       line_out, hold_ready, all_sent;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  logic exp_s [BUF_N];
  logic got_s [BUF_N];
  int   exp_n;
  int   got_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_tx_serializer i_usart_tx_serializer (
    .clk(clk), .rst(rst), .tx_tick(tx_tick), .async_mode(async_mode),
    .len_code(len_code), .par_on(par_on), .par_even(par_even),
    .stop_code(stop_code), .rate_code(rate_code), .dual_sync(dual_sync),
    .sync_a(sync_a), .sync_b(sync_b), .tx_enable(tx_enable), .cts_n(cts_n),
    .force_break(force_break), .wr_valid(wr_valid), .wr_data(wr_data),
    .line_out(line_out), .hold_ready(hold_ready), .all_sent(all_sent)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(logic v, int cnt);
    for (int k = 0; k < cnt; k++) begin
      exp_s[exp_n] = v;
      exp_n++;
    end
  endtask

  task automatic add_char(bit asy, int dl, bit pe, bit pev, int stop, int fact, logic [7:0] d);
    logic p;
    p = 1'b0;
    if (asy) push(1'b0, fact);
    for (int i = 0; i < dl; i++) begin
      push(d[i], fact);
      p = p ^ d[i];
    end
    if (pe) push(pev ? p : ~p, fact);
    if (asy) begin
      push(1'b1, fact);
      if (stop == 1) push(1'b1, (fact > 1) ? fact / 2 : fact);
      else if (stop == 2) push(1'b1, fact);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tx_tick = 1'b1;
    @(negedge clk) tx_tick = 1'b0;
    got_s[got_n] = line_out;
    got_n++;
  endtask

  task automatic tick_to(int n);
    while (got_n < n) do_tick();
  endtask

  task automatic write(logic [7:0] d);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic cmp_stream(string req);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && got_s[i] !== exp_s[i]) bad = i;
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s stream bit %0d: actual %0d expected %0d", req, bad,
               got_s[bad], exp_s[bad]);
    end
  endtask

  function automatic int fact_of(int rc);
    return (rc == 0) ? 1 : (rc == 1) ? 16 : 64;
  endfunction

  // R4 R5 R3 R9: two back-to-back async characters
  task automatic run_async(int lc, bit pe, bit pev, int stop, int rc, logic [7:0] a, logic [7:0] b);
    @(negedge clk) begin
      async_mode = 1'b1; len_code = 2'(lc); par_on = pe; par_even = pev;
      stop_code = 2'(stop); rate_code = 2'(rc); tx_enable = 1'b1; cts_n = 1'b0;
    end
    exp_n = 0; got_n = 0;
    add_char(1'b1, 5 + lc, pe, pev, stop, fact_of(rc), a);
    add_char(1'b1, 5 + lc, pe, pev, stop, fact_of(rc), b);
    push(1'b1, 3);
    write(a);
    chk(!hold_ready, "R3", "hold_ready after write", hold_ready, 0);
    chk(!all_sent, "R9", "all_sent with byte pending", all_sent, 0);
    do_tick();
    chk(hold_ready, "R3", "hold_ready after load", hold_ready, 1);
    chk(!all_sent, "R9", "all_sent while shifting", all_sent, 0);
    write(b);
    tick_to(exp_n);
    cmp_stream((rc == 0) ? "R4" : "R5");
    chk(all_sent, "R9", "all_sent after frames", all_sent, 1);
  endtask

  // R6 R7: fill pattern from idle
  task automatic run_fill(int lc, bit pe, bit pev, bit two, logic [7:0] sa, logic [7:0] sb);
    @(negedge clk) begin
      async_mode = 1'b0; len_code = 2'(lc); par_on = pe; par_even = pev;
      dual_sync = two; sync_a = sa; sync_b = sb; tx_enable = 1'b1;
    end
    exp_n = 0; got_n = 0;
    for (int c = 0; c < 4; c++)
      add_char(1'b0, 5 + lc, pe, pev, 0, 1, (two && c[0]) ? sb : sa);
    tick_to(2);
    chk(all_sent, "R9", "all_sent during fill", all_sent, 1);
    tick_to(exp_n);
    cmp_stream("R7");
    @(negedge clk) tx_enable = 1'b0;
    do_tick(); do_tick();
    chk(line_out, "R8", "sync line while disabled", line_out, 1);
  endtask

  // R6 R7 R8 R9: data held while stopped, then data and restarted fill
  task automatic run_sync_data(int lc, bit pe, bit two, logic [7:0] d, logic [7:0] sa, logic [7:0] sb);
    @(negedge clk) begin
      async_mode = 1'b0; len_code = 2'(lc); par_on = pe; par_even = 1'b1;
      dual_sync = two; sync_a = sa; sync_b = sb; tx_enable = 1'b0;
    end
    write(d);
    chk(all_sent, "R9", "all_sent held while stopped", all_sent, 1);
    got_n = 0;
    do_tick(); do_tick(); do_tick();
    chk(got_s[2] && got_s[1] && got_s[0], "R8", "line while held", got_s[2], 1);
    chk(!hold_ready, "R8", "byte still held", hold_ready, 0);
    @(negedge clk) tx_enable = 1'b1;
    exp_n = 0; got_n = 0;
    add_char(1'b0, 5 + lc, pe, 1'b1, 0, 1, d);
    add_char(1'b0, 5 + lc, pe, 1'b1, 0, 1, sa);
    add_char(1'b0, 5 + lc, pe, 1'b1, 0, 1, two ? sb : sa);
    tick_to(exp_n);
    cmp_stream("R6");
    @(negedge clk) tx_enable = 1'b0;
    do_tick(); do_tick();
  endtask

  // R8 R10: stop in the middle of a frame via command or clear-to-send
  task automatic run_stop(bit use_cts, logic [7:0] a, logic [7:0] b);
    logic v;
    @(negedge clk) begin
      async_mode = 1'b1; len_code = 2'd3; par_on = 1'b0; stop_code = 2'd0;
      rate_code = 2'd0; tx_enable = 1'b1; cts_n = 1'b0;
    end
    exp_n = 0; got_n = 0;
    add_char(1'b1, 8, 1'b0, 1'b0, 0, 1, a);
    push(1'b1, 6);
    write(a);
    do_tick(); do_tick(); do_tick();
    v = line_out;
    repeat (20) @(negedge clk);
    chk(line_out == v, "R10", "line without strobe", line_out, v);
    @(negedge clk) if (use_cts) cts_n = 1'b1; else tx_enable = 1'b0;
    write(b);
    tick_to(exp_n);
    cmp_stream("R8");
    chk(all_sent && !hold_ready, "R8", "held while stopped", all_sent, 1);
    @(negedge clk) begin cts_n = 1'b0; tx_enable = 1'b1; end
    exp_n = 0; got_n = 0;
    add_char(1'b1, 8, 1'b0, 1'b0, 0, 1, b);
    push(1'b1, 2);
    tick_to(exp_n);
    cmp_stream("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(line_out, "R1", "line after reset", line_out, 1);
    chk(hold_ready, "R1", "hold_ready after reset", hold_ready, 1);
    chk(all_sent, "R1", "all_sent after reset", all_sent, 1);

    @(negedge clk) force_break = 1'b1;
    @(negedge clk);
    chk(!line_out, "R2", "line under break", line_out, 0);
    force_break = 1'b0;
    @(negedge clk);
    chk(line_out, "R2", "line after break", line_out, 1);

    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 3; st++)
          run_async(lc, pm != 0, pm == 1, st, 0, 8'(8'h5A ^ (lc * 53 + pm * 29 + st * 7)),
                    8'(8'hC3 ^ (lc * 17 + pm * 41 + st * 11)));
    for (int rc = 1; rc < 3; rc++)
      for (int st = 0; st < 3; st++)
        run_async(st, st == 1, rc == 2, st, rc, 8'(8'h96 + rc * 13 + st), 8'(8'h21 ^ (rc * 70 + st)));

    // R3: a write to a full register is discarded
    @(negedge clk) begin tx_enable = 1'b0; rate_code = 2'd0; len_code = 2'd3;
                         par_on = 1'b0; stop_code = 2'd0; end
    write(8'hA5);
    write(8'h3C);
    @(negedge clk) tx_enable = 1'b1;
    exp_n = 0; got_n = 0;
    add_char(1'b1, 8, 1'b0, 1'b0, 0, 1, 8'hA5);
    push(1'b1, 12);
    tick_to(exp_n);
    cmp_stream("R3");

    run_stop(1'b0, 8'h4E, 8'hB1);
    run_stop(1'b1, 8'h0F, 8'hE2);

    for (int lc = 0; lc < 4; lc++) begin
      run_sync_data(lc, lc[0], 1'b1, 8'(8'h6D + lc * 9), 8'h16, 8'hE9);
      run_fill(lc, lc[1], lc[0], 1'b1, 8'h16, 8'hE9);
      run_fill(lc, 1'b0, 1'b0, 1'b0, 8'(8'h32 + lc), 8'hFF);
      run_sync_data(lc, 1'b0, 1'b0, 8'(8'hA1 - lc * 5), 8'h2B, 8'h55);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule